// File: doc/BRIEF.md
# MAC Address Lookup Table Engine

This block is the address resolution stage of a small multi-port Ethernet switch. It keeps a table of address entries and, for each frame, takes the destination MAC address and the port the frame arrived on. It then returns the set of ports the frame should leave by. Software never sees the table directly. It selects an entry by writing an index to a table-control register and moves the entry through three 32-bit word registers, in either direction.

Each entry carries a type code, a 48-bit MAC address and a group of flag bits above bit 63. The flag bits mean different things for unicast and multicast entries. Every port also has a two-bit forwarding state, and only ports in the forwarding state may send or receive data frames. A lookup walks the table one entry per clock and stops at the first entry that matches. If nothing matches, the frame is flooded. The resulting mask is always restricted to forwarding ports other than the ingress port.

Top module: `addr_lookup_engine`

## Requirements
- R1: After reset the global control register, the table-control register, the word registers and every port state read 0, all entries are free (type 0) and the engine is disabled.
- R2: Writing an index to the table-control register (address 1) with bit 31 clear loads that entry into the word registers on the same edge. Word 0 (address 2) holds entry bits ENTRY_W-1:64 right-aligned, word 1 (address 3) holds bits 63:32 and word 2 (address 4) holds bits 31:0.
- R3: Writing an index to the table-control register with bit 31 set commits the word registers, packed as in R2, into that entry.
- R4: In the global control register (address 0), bit 31 enables lookups and bit 2 is a stored mode bit; both read back. Writing bit 30 as 1 returns every entry to all-zero (free) on that edge, and bit 30 always reads back 0.
- R5: An entry matches when its type (bits 61:60) is 1 (address) or 3 (VLAN plus address) and its bits 47:0 equal the looked-up MAC. Types 0 and 2 never match, and the lowest matching index wins.
- R6: A matching entry with bit 40 clear is unicast. Its raw mask is one-hot at the port number in bits 67:66, or empty if its blocked bit 65 is set.
- R7: A matching entry with bit 40 set is multicast. Its raw mask is the PORTS-bit field starting at bit 66.
- R8: The returned mask is the raw mask ANDed with the ports whose state is 3 (forwarding), with the ingress port removed. It is empty if the ingress port is not forwarding. States 0, 1 and 2 (disabled, blocking, learning) do not forward.
- R9: On a miss, lk_hit is 0 and the raw mask is all ports, so the frame floods to every forwarding port except the ingress port.
- R10: A request accepted on an edge while the engine is idle raises lk_done for exactly one cycle. That happens m+1 edges later for a hit at index m, and ENTRIES edges later for a miss. lk_busy is high meanwhile, and requests made while busy are ignored.
- R11: With the engine disabled, a lookup completes one edge after acceptance with lk_hit 0 and an empty mask.
- R12: Each port state register (address 8+p) keeps only the two low bits of a write, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| lk_req | input | 1 | Lookup request, accepted when lk_busy is low |
| lk_mac | input | 48 | Destination MAC address to look up |
| lk_port | input | $clog2(PORTS) | Ingress port number |
| lk_busy | output | 1 | Lookup scan in progress |
| lk_done | output | 1 | One-cycle pulse, result valid |
| lk_hit | output | 1 | An entry matched |
| lk_mask | output | PORTS | Egress port mask |

## Verification
The bench targets the places where a lookup engine usually fails quietly. A duplicate address must resolve to the lowest index, and a design that kept scanning would return the later entry's port. A VLAN-only entry that carries the searched address must be skipped, and a design that ignored the type would report a false hit. Blocked unicast entries, a non-forwarding ingress port and the ingress bit itself must all empty the mask, and a wrong design would send the frame back out, or out of a port that is learning. The bench also checks the exact completion cycle for a first-entry hit, a last-entry hit and a miss. It checks that a request made mid-scan does not restart the walk, and that a clear leaves every entry unmatched and every word zero on load.

// File: rtl/lut_pkg.sv
package lut_pkg;
   localparam int MAC_W    = 48;
   localparam int REG_AW   = 4;
   // Entry field positions (the search logic decodes these)
   localparam int TYPE_LSB = 60;
   localparam int SUBT_LSB = 62;
   localparam int SEC_BIT  = 64;
   localparam int BLK_BIT  = 65;
   localparam int DST_LSB  = 66;
   localparam int MC_BIT   = 40;
   // Control bit positions
   localparam int GC_EN     = 31;
   localparam int GC_CLR    = 30;
   localparam int GC_MODE   = 2;
   localparam int TC_COMMIT = 31;

   typedef enum logic [1:0] {
      ET_FREE  = 2'd0,
      ET_ADDR  = 2'd1,
      ET_VLAN  = 2'd2,
      ET_VADDR = 2'd3
   } ent_type_e;

   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_BLOCK = 2'd1,
      PS_LEARN = 2'd2,
      PS_FWD   = 2'd3
   } port_state_e;

   localparam logic [REG_AW-1:0] RA_GCTL = 4'd0;
   localparam logic [REG_AW-1:0] RA_TCTL = 4'd1;
   localparam logic [REG_AW-1:0] RA_W0   = 4'd2;
   localparam logic [REG_AW-1:0] RA_W1   = 4'd3;
   localparam logic [REG_AW-1:0] RA_W2   = 4'd4;
   localparam logic [REG_AW-1:0] RA_PST  = 4'd8;
endpackage

// File: rtl/lut_store.sv
module lut_store #(
   parameter int ENTRIES = 16,
   parameter int ENTRY_W = 69,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx_a,
   output logic [ENTRY_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]   rd_idx_b,
   output logic [ENTRY_W-1:0] rd_data_b
);
   logic [ENTRIES-1:0][ENTRY_W-1:0] ent_arr;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [ENTRY_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            q <= wr_data;
         end
      end
      assign ent_arr[i] = q;
   end

   assign rd_data_a = ent_arr[rd_idx_a];
   assign rd_data_b = ent_arr[rd_idx_b];
endmodule

// File: rtl/lut_regs.sv
module lut_regs
   import lut_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PORTS   = 3,
   parameter int ENTRY_W = 69,
   parameter int IDX_W   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [REG_AW-1:0]       cfg_addr,
   input  logic [31:0]             cfg_wdata,
   output logic [31:0]             cfg_rdata,
   output logic                    eng_en,
   output logic                    tbl_clr,
   output logic                    tbl_wr,
   output logic [IDX_W-1:0]        tbl_idx,
   output logic [ENTRY_W-1:0]      tbl_wdata,
   input  logic [ENTRY_W-1:0]      tbl_rdata,
   output logic [PORTS-1:0][1:0]   port_st
);
   localparam int W0_W = ENTRY_W - 64;

   logic             mode_q;
   logic [IDX_W-1:0] idx_q;
   logic [W0_W-1:0]  w0_q;
   logic [31:0]      w1_q;
   logic [31:0]      w2_q;
   logic             wr_gctl;
   logic             wr_tctl;

   assign wr_gctl   = cfg_we && (cfg_addr == RA_GCTL);
   assign wr_tctl   = cfg_we && (cfg_addr == RA_TCTL);
   assign tbl_idx   = cfg_wdata[IDX_W-1:0];
   assign tbl_wr    = wr_tctl && cfg_wdata[TC_COMMIT];
   assign tbl_clr   = wr_gctl && cfg_wdata[GC_CLR];
   assign tbl_wdata = {w0_q, w1_q, w2_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eng_en <= 1'b0;
         mode_q <= 1'b0;
         idx_q  <= '0;
         w0_q   <= '0;
         w1_q   <= '0;
         w2_q   <= '0;
      end else if (cfg_we) begin
         unique case (cfg_addr)
            RA_GCTL: begin
               eng_en <= cfg_wdata[GC_EN];
               mode_q <= cfg_wdata[GC_MODE];
            end
            RA_TCTL: begin
               idx_q <= cfg_wdata[IDX_W-1:0];
               if (!cfg_wdata[TC_COMMIT]) begin
                  {w0_q, w1_q, w2_q} <= tbl_rdata;
               end
            end
            RA_W0:   w0_q <= cfg_wdata[W0_W-1:0];
            RA_W1:   w1_q <= cfg_wdata;
            RA_W2:   w2_q <= cfg_wdata;
            default: ;
         endcase
      end
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_pst
      logic [1:0] st_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q <= PS_OFF;
         end else if (cfg_we && (cfg_addr == RA_PST + REG_AW'(p))) begin
            st_q <= cfg_wdata[1:0];
         end
      end
      assign port_st[p] = st_q;
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RA_GCTL: begin
            cfg_rdata[GC_EN]   = eng_en;
            cfg_rdata[GC_MODE] = mode_q;
         end
         RA_TCTL: cfg_rdata[IDX_W-1:0] = idx_q;
         RA_W0:   cfg_rdata[W0_W-1:0]  = w0_q;
         RA_W1:   cfg_rdata = w1_q;
         RA_W2:   cfg_rdata = w2_q;
         default: begin
            for (int p = 0; p < PORTS; p++) begin
               if (cfg_addr == RA_PST + REG_AW'(p)) begin
                  cfg_rdata[1:0] = port_st[p];
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/lut_search.sv
module lut_search
   import lut_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PORTS   = 3,
   parameter int ENTRY_W = 69,
   parameter int IDX_W   = 4,
   parameter int PORT_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eng_en,
   input  logic [PORTS-1:0]   fwd_set,
   input  logic               req,
   input  logic [MAC_W-1:0]   mac,
   input  logic [PORT_W-1:0]  port,
   output logic [IDX_W-1:0]   scan_idx,
   input  logic [ENTRY_W-1:0] scan_entry,
   output logic               busy,
   output logic               done,
   output logic               hit,
   output logic [PORTS-1:0]   mask
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   typedef enum logic {S_IDLE, S_SCAN} st_e;

   st_e               st_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [MAC_W-1:0]  mac_q;
   logic [PORT_W-1:0] port_q;

   logic [1:0]        etype;
   logic              match;
   logic              finish;
   logic [PORTS-1:0]  uc_mask;
   logic [PORTS-1:0]  raw_mask;
   logic [PORTS-1:0]  ing_bit;
   logic              ing_ok;
   logic [PORTS-1:0]  res_mask;
   logic              unused_entry;

   assign etype = scan_entry[TYPE_LSB +: 2];
   assign match = ((etype == ET_ADDR) || (etype == ET_VADDR)) &&
                  (scan_entry[MAC_W-1:0] == mac_q);

   for (genvar p = 0; p < PORTS; p++) begin : g_dec
      assign uc_mask[p] = (scan_entry[DST_LSB +: 2] == 2'(p));
      assign ing_bit[p] = (port_q == PORT_W'(p));
   end

   always_comb begin
      if (!match) begin
         raw_mask = '1;
      end else if (scan_entry[MC_BIT]) begin
         raw_mask = scan_entry[DST_LSB +: PORTS];
      end else if (scan_entry[BLK_BIT]) begin
         raw_mask = '0;
      end else begin
         raw_mask = uc_mask;
      end
   end

   assign ing_ok   = |(fwd_set & ing_bit);
   assign res_mask = (eng_en && ing_ok) ? (raw_mask & fwd_set & ~ing_bit) : '0;
   assign finish   = !eng_en || match || (ptr_q == LAST);
   assign scan_idx = ptr_q;
   assign busy     = (st_q == S_SCAN);
   assign unused_entry = ^{scan_entry[SEC_BIT], scan_entry[SUBT_LSB +: 2]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ptr_q  <= '0;
         mac_q  <= '0;
         port_q <= '0;
         done   <= 1'b0;
         hit    <= 1'b0;
         mask   <= '0;
      end else begin
         done <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (req) begin
                  mac_q  <= mac;
                  port_q <= port;
                  ptr_q  <= '0;
                  st_q   <= S_SCAN;
               end
            end
            S_SCAN: begin
               if (finish) begin
                  done <= 1'b1;
                  hit  <= eng_en && match;
                  mask <= res_mask;
                  st_q <= S_IDLE;
               end else begin
                  ptr_q <= ptr_q + 1'b1;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/addr_lookup_engine.sv
module addr_lookup_engine
   import lut_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PORTS   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [3:0]               cfg_addr,
   input  logic [31:0]              cfg_wdata,
   output logic [31:0]              cfg_rdata,
   input  logic                     lk_req,
   input  logic [47:0]              lk_mac,
   input  logic [$clog2(PORTS)-1:0] lk_port,
   output logic                     lk_busy,
   output logic                     lk_done,
   output logic                     lk_hit,
   output logic [PORTS-1:0]         lk_mask
);
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int PORT_W  = $clog2(PORTS);
   localparam int ENTRY_W = DST_LSB + PORTS;

   if (PORTS < 2 || PORTS > 4) begin : g_bad_ports
      $error("PORTS must lie in 2..4");
   end
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end

   logic                   eng_en;
   logic                   tbl_clr;
   logic                   tbl_wr;
   logic [IDX_W-1:0]       tbl_idx;
   logic [ENTRY_W-1:0]     tbl_wdata;
   logic [ENTRY_W-1:0]     tbl_rdata;
   logic [IDX_W-1:0]       scan_idx;
   logic [ENTRY_W-1:0]     scan_entry;
   logic [PORTS-1:0][1:0]  port_st;
   logic [PORTS-1:0]       fwd_set;

   for (genvar p = 0; p < PORTS; p++) begin : g_fwd
      assign fwd_set[p] = (port_st[p] == PS_FWD);
   end

   lut_regs #(
      .ENTRIES (ENTRIES),
      .PORTS   (PORTS),
      .ENTRY_W (ENTRY_W),
      .IDX_W   (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .eng_en    (eng_en),
      .tbl_clr   (tbl_clr),
      .tbl_wr    (tbl_wr),
      .tbl_idx   (tbl_idx),
      .tbl_wdata (tbl_wdata),
      .tbl_rdata (tbl_rdata),
      .port_st   (port_st)
   );

   lut_store #(
      .ENTRIES (ENTRIES),
      .ENTRY_W (ENTRY_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tbl_clr),
      .wr_en     (tbl_wr),
      .wr_idx    (tbl_idx),
      .wr_data   (tbl_wdata),
      .rd_idx_a  (tbl_idx),
      .rd_data_a (tbl_rdata),
      .rd_idx_b  (scan_idx),
      .rd_data_b (scan_entry)
   );

   lut_search #(
      .ENTRIES (ENTRIES),
      .PORTS   (PORTS),
      .ENTRY_W (ENTRY_W),
      .IDX_W   (IDX_W),
      .PORT_W  (PORT_W)
   ) u_search (
      .clk        (clk),
      .rst_n      (rst_n),
      .eng_en     (eng_en),
      .fwd_set    (fwd_set),
      .req        (lk_req),
      .mac        (lk_mac),
      .port       (lk_port),
      .scan_idx   (scan_idx),
      .scan_entry (scan_entry),
      .busy       (lk_busy),
      .done       (lk_done),
      .hit        (lk_hit),
      .mask       (lk_mask)
   );
endmodule

// File: rtl/addr_lookup_engine_chk.sv
module addr_lookup_engine_chk #(
   parameter int ENTRIES = 16,
   parameter int PORTS   = 3,
   parameter int PORT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_req,
   input logic [PORT_W-1:0] lk_port,
   input logic              lk_busy,
   input logic              lk_done,
   input logic              lk_hit,
   input logic [PORTS-1:0]  lk_mask,
   input logic              eng_en,
   input logic [PORTS-1:0]  fwd_set
);
   localparam int CW = $clog2(ENTRIES) + 2;

   logic [PORT_W-1:0] port_q;
   logic [CW-1:0]     busy_cnt;
   logic [PORTS-1:0]  ing;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_q   <= '0;
         busy_cnt <= '0;
      end else begin
         if (lk_req && !lk_busy) port_q <= lk_port;
         if (!lk_busy) busy_cnt <= '0;
         else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
      end
   end

   always_comb begin
      for (int p = 0; p < PORTS; p++) ing[p] = (port_q == PORT_W'(p));
   end

   // R10: a result is announced for a single cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |=> !lk_done);

   // R10: an idle request starts a scan
   a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_busy) |=> lk_busy);

   // R10: a scan never lasts longer than the table
   a_r10_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CW'(ENTRIES));

   // R8: never back out of the ingress port
   a_r8_no_ingress: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> ((lk_mask & ing) == '0));

   // R8: only forwarding ports may appear in the mask
   a_r8_fwd_only: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> ((lk_mask & ~$past(fwd_set)) == '0));

   // R11: a disabled engine forwards nothing
   a_r11_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && !$past(eng_en)) |-> (lk_mask == '0 && !lk_hit));

   // R9: a miss floods to the other forwarding ports
   a_r9_flood: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && !lk_hit && $past(eng_en) && (($past(fwd_set) & ing) != '0))
      |-> (lk_mask == ($past(fwd_set) & ~ing)));
endmodule

bind addr_lookup_engine addr_lookup_engine_chk #(
   .ENTRIES (ENTRIES),
   .PORTS   (PORTS),
   .PORT_W  (PORT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lk_req  (lk_req),
   .lk_port (lk_port),
   .lk_busy (lk_busy),
   .lk_done (lk_done),
   .lk_hit  (lk_hit),
   .lk_mask (lk_mask),
   .eng_en  (eng_en),
   .fwd_set (fwd_set)
);

// File: tb/addr_lookup_engine_test.sv
module addr_lookup_engine_test;
   localparam int N  = 16;
   localparam int NP = 3;
   localparam int EW = 69;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_req = 1'b0;
   logic [47:0] lk_mac = '0;
   logic [1:0]  lk_port = '0;
   logic        lk_busy, lk_done, lk_hit;
   logic [2:0]  lk_mask;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [EW-1:0] tbl [N];
   logic [1:0]    pst [NP];
   bit            en = 0;
   logic [47:0]   pool [8];

   always #10 clk = ~clk;

   addr_lookup_engine #(.ENTRIES(N), .PORTS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req(lk_req),
      .lk_mac(lk_mac), .lk_port(lk_port), .lk_busy(lk_busy),
      .lk_done(lk_done), .lk_hit(lk_hit), .lk_mask(lk_mask)
   );

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string tag,
                      input logic [EW-1:0] act, input logic [EW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic commit(input int idx, input logic [EW-1:0] e);
      wr(4'd2, {27'd0, e[68:64]});
      wr(4'd3, e[63:32]);
      wr(4'd4, e[31:0]);
      wr(4'd1, 32'h8000_0000 | 32'(idx));
      tbl[idx] = e;
   endtask

   task automatic set_pst(input int p, input logic [31:0] d);
      wr(4'(8 + p), d);
      pst[p] = d[1:0];
   endtask

   function automatic logic [EW-1:0] mk_uc(input logic [47:0] mac, input int dst, input bit blk);
      logic [EW-1:0] e = '0;
      e[61:60] = 2'd1; e[47:0] = mac; e[40] = 1'b0;
      e[65] = blk; e[67:66] = 2'(dst);
      return e;
   endfunction

   function automatic logic [EW-1:0] mk_mc(input logic [47:0] mac, input logic [2:0] m);
      logic [EW-1:0] e = '0;
      e[61:60] = 2'd1; e[47:0] = mac; e[40] = 1'b1;
      e[63:62] = 2'd3; e[68:66] = m;
      return e;
   endfunction

   // Expected behaviour from R5..R11
   function automatic void model(input logic [47:0] mac, input int port,
                                 output bit hit, output logic [2:0] mask, output int lat);
      logic [2:0] fwd, ing, raw;
      logic [EW-1:0] e;
      int idx = -1;
      hit = 0; mask = '0;
      if (!en) begin lat = 1; return; end
      for (int i = 0; i < N; i++) begin
         if (idx < 0 && (tbl[i][61:60] == 2'd1 || tbl[i][61:60] == 2'd3) &&
             tbl[i][47:0] == mac) idx = i;
      end
      for (int p = 0; p < NP; p++) begin
         fwd[p] = (pst[p] == 2'd3);
         ing[p] = (port == p);
      end
      if (idx >= 0) begin
         hit = 1; lat = idx + 1; e = tbl[idx];
         if (e[40]) raw = e[68:66];
         else if (e[65]) raw = '0;
         else begin
            raw = '0;
            if (e[67:66] < 2'd3) raw[e[67:66]] = 1'b1;
         end
      end else begin
         lat = N; raw = 3'b111;
      end
      mask = ((fwd & ing) != '0) ? (raw & fwd & ~ing) : '0;
   endfunction

   task automatic lookup(input logic [47:0] mac, input logic [1:0] port,
                         output bit hit, output logic [2:0] mask, output int lat);
      @(negedge clk);
      lk_req = 1'b1; lk_mac = mac; lk_port = port;
      @(posedge clk);
      @(negedge clk);
      lk_req = 1'b0;
      lat = 0;
      do begin
         @(posedge clk); lat++;
         @(negedge clk);
      end while (!lk_done && lat < N + 8);
      hit = lk_hit; mask = lk_mask;
   endtask

   task automatic look_chk(input logic [47:0] mac, input logic [1:0] port, input string tag);
      bit h, eh; logic [2:0] m, em; int l, el;
      model(mac, int'(port), eh, em, el);
      lookup(mac, port, h, m, l);
      chk(h == eh, {tag, " hit"}, EW'(h), EW'(eh));
      chk(m == em, {tag, " mask"}, EW'(m), EW'(em));
      chk(l == el, {tag, " latency R10"}, EW'(l), EW'(el));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] d;
      logic [EW-1:0] e;
      bit h; logic [2:0] m; int l, extra;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) tbl[i] = '0;
      for (int p = 0; p < NP; p++) pst[p] = 2'd0;
      for (int k = 0; k < 8; k++) pool[k] = {7'd0, 1'(k & 1), 40'hA0_B0C0_D000 + 40'(k)};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, d); chk(d == 0, "R1 global control after reset", EW'(d), 0);
      rd(4'd1, d); chk(d == 0, "R1 table control after reset", EW'(d), 0);
      rd(4'd3, d); chk(d == 0, "R1 word 1 after reset", EW'(d), 0);
      rd(4'd9, d); chk(d == 0, "R1 port state after reset", EW'(d), 0);
      // R11 disabled engine
      look_chk(48'h0211_2233_4455, 2'd0, "R11 disabled");

      // R4 enable and mode bits read back
      wr(4'd0, 32'h8000_0004); en = 1;
      rd(4'd0, d); chk(d == 32'h8000_0004, "R4 control readback", EW'(d), EW'(32'h8000_0004));
      // R1 all ports disabled: nothing forwarded
      look_chk(48'h0211_2233_4455, 2'd1, "R1 no forwarding ports");

      // R12 port state keeps two bits
      set_pst(0, 32'hFFFF_FFFF);
      rd(4'd8, d); chk(d == 3, "R12 port state width", EW'(d), 3);
      set_pst(1, 32'd3); set_pst(2, 32'd3);

      // R3 commit, R2 load and word packing
      e = mk_uc(48'h0211_2233_4455, 2, 0);
      e[64] = 1'b1;
      commit(5, e);
      wr(4'd3, 32'h0); wr(4'd2, 32'h0);
      wr(4'd1, 32'd5);
      rd(4'd2, d); chk(d == {27'd0, e[68:64]}, "R2 word 0 high bits", EW'(d), EW'(e[68:64]));
      rd(4'd3, d); chk(d == e[63:32], "R2 word 1", EW'(d), EW'(e[63:32]));
      rd(4'd4, d); chk(d == e[31:0], "R2 word 2", EW'(d), EW'(e[31:0]));
      rd(4'd1, d); chk(d == 5, "R2 table index readback", EW'(d), 5);

      // R6 unicast hit, R8 ingress exclusion
      look_chk(48'h0211_2233_4455, 2'd0, "R6 unicast hit");
      look_chk(48'h0211_2233_4455, 2'd2, "R8 unicast to ingress");
      commit(2, mk_uc(48'h0266_7788_99AA, 1, 1));
      look_chk(48'h0266_7788_99AA, 2'd0, "R6 blocked unicast");
      // R7 multicast
      commit(7, mk_mc(48'h0100_5E00_0001, 3'b111));
      look_chk(48'h0100_5E00_0001, 2'd1, "R7 multicast mask");
      set_pst(2, 32'd1);
      look_chk(48'h0100_5E00_0001, 2'd1, "R8 blocking port removed");
      set_pst(2, 32'd3);
      // R9 miss flood
      look_chk(48'h0AFF_FFFF_FFFF, 2'd0, "R9 miss flood");
      // R8 ingress learning
      set_pst(0, 32'd2);
      look_chk(48'h0AFF_FFFF_FFFF, 2'd0, "R8 ingress not forwarding");
      set_pst(0, 32'd3);
      // R5 type filter and lowest index
      e = mk_uc(48'h0233_0000_0001, 0, 0); e[61:60] = 2'd2;
      commit(1, e);
      commit(9, mk_uc(48'h0233_0000_0001, 1, 0));
      commit(12, mk_uc(48'h0233_0000_0001, 2, 0));
      look_chk(48'h0233_0000_0001, 2'd0, "R5 first match wins");
      e = mk_uc(48'h0244_0000_0002, 0, 0); e[61:60] = 2'd3;
      commit(11, e);
      look_chk(48'h0244_0000_0002, 2'd2, "R5 vlan plus address type");
      // R10 last entry
      commit(15, mk_uc(48'h0255_0000_0003, 1, 0));
      look_chk(48'h0255_0000_0003, 2'd2, "R10 last entry");

      // R10 request while busy is ignored
      begin
         bit eh; logic [2:0] em; int el;
         model(48'h0255_0000_0003, 2, eh, em, el);
         @(negedge clk);
         lk_req = 1'b1; lk_mac = 48'h0255_0000_0003; lk_port = 2'd2;
         @(posedge clk); @(negedge clk);
         lk_req = 1'b0; l = 0;
         @(posedge clk); l++; @(negedge clk);
         lk_req = 1'b1; lk_mac = 48'h0211_2233_4455; lk_port = 2'd0;
         @(posedge clk); l++; @(negedge clk);
         lk_req = 1'b0;
         while (!lk_done && l < N + 8) begin
            @(posedge clk); l++; @(negedge clk);
         end
         chk(lk_mask == em, "R10 busy request ignored mask", EW'(lk_mask), EW'(em));
         chk(l == el, "R10 busy request ignored latency", EW'(l), EW'(el));
         extra = 0;
         repeat (20) begin @(negedge clk); if (lk_done) extra++; end
         chk(extra == 0, "R10 single done pulse", EW'(extra), 0);
      end

      // R4 clear
      wr(4'd0, 32'hC000_0000);
      for (int i = 0; i < N; i++) tbl[i] = '0;
      rd(4'd0, d); chk(d == 32'h8000_0000, "R4 clear bit reads zero", EW'(d), EW'(32'h8000_0000));
      wr(4'd1, 32'd5);
      rd(4'd4, d); chk(d == 0, "R4 cleared entry word 2", EW'(d), 0);
      rd(4'd2, d); chk(d == 0, "R4 cleared entry word 0", EW'(d), 0);
      look_chk(48'h0211_2233_4455, 2'd0, "R4 lookup after clear");

      // R11 disable again
      wr(4'd0, 32'h0); en = 0;
      look_chk(pool[1], 2'd1, "R11 disabled after use");
      wr(4'd0, 32'h8000_0000); en = 1;

      // Random mix: R5 R6 R7 R8 R9 R10
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 9);
         if (op < 3) begin
            e = {$urandom, $urandom, $urandom};
            e[47:0] = pool[$urandom_range(0, 7)];
            e[61:60] = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
            commit($urandom_range(0, N - 1), e);
         end else if (op == 3) begin
            set_pst($urandom_range(0, NP - 1), $urandom);
         end else begin
            look_chk((op == 9) ? 48'h0FEE_DDCC_BBAA : pool[$urandom_range(0, 7)],
                     2'($urandom_range(0, 3)), "R8 random lookup");
         end
      end

      summary();
   end
endmodule